// File: doc/BRIEF.md
# Byte-wide control/status register bank

This block is a small register bank that sits on an 8-bit register bus. It holds a 32-bit control value that software writes and the device may overwrite, a 32-bit status value that only the device updates, and an action location whose bus write emits a single-cycle kick pulse. Each 32-bit value is spread over four neighbouring byte addresses with the most significant byte at the lowest address.

Reads are qualified by an explicit read-enable input, so an address that is merely parked on the bus, with both enables low, never counts as a read and never raises the read-side-effect pulse. Writes to the control value are staged: the three upper bytes collect in a shadow, and the full value changes in one step when its lowest byte, at base+3, is written. The kick pulse loads a fixed pattern (default 0xDEADBEEF) into the control value through the device override path. On the same edge, the status value samples the control value as it stood before that load.

Top module: `csr_byte_bank`

## Requirements
- R1: After reset both the control value (`ctl_value`) and the status value read back 0x12345678, `bus_rdata` is 0x00 and `kick_pulse` is low.
- R2: Address 0 is the action location, addresses 1..4 hold the control value and 5..8 the status value; within each value the byte at base+0 is bits 31:24 and the byte at base+3 is bits 7:0.
- R3: Bus writes to base+0..base+2 of the control value leave `ctl_value` unchanged; a write to base+3 updates all 32 bits at once from the three staged bytes and the written byte, visible the cycle after that write, and four byte writes then read back the same value.
- R4: Bus writes to status addresses 5..8 never change the status value.
- R5: A bus write (`bus_we`=1) to address 0 raises `kick_pulse` in that same cycle only, and `ctl_value` equals 0xDEADBEEF in the following cycle.
- R6: On a kick the status value takes the control value held before that kick's load, so a second kick is needed before status reads 0xDEADBEEF.
- R7: `stat_rd_pulse` is high only in a cycle with `bus_re`=1 and a status address; an address held with `bus_we`=0 and `bus_re`=0 produces no pulse.
- R8: Read data is registered: it holds the addressed byte from the cycle after a `bus_re` cycle, keeps its value while `bus_re` is low, and is 0x00 for address 0 and for addresses above 8.
- R9: `dev_ovr_en` loads `dev_ovr_data` into the control value on the next edge and wins over a bus commit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte address |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| kick_pulse | output | 1 | Single-cycle action strobe |
| stat_rd_pulse | output | 1 | Read-side-effect strobe for the status value |
| ctl_value | output | 32 | Current control value |
| dev_ovr_en | input | 1 | Device override of the control value |
| dev_ovr_data | input | 32 | Device override data |

## Verification
On every cycle the assertions check that the kick and read pulses only follow their qualifying enables, that the control value moves only after a commit or an override, that a kick loads the fixed pattern while status takes the prior control value, and that read data holds without read enable and is zero off the map. Only the bench scenarios show the byte ordering of full 32-bit round trips, the atomic commit after partial writes, status immunity to bus writes, the two-kick sequence and override priority over a simultaneous commit.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int BYTE_W = 8;

  // Byte of a value by lane, lane 0 being the most significant byte.
  function automatic logic [BYTE_W-1:0] lane_byte(input logic [63:0] v,
                                                  input int nbytes,
                                                  input int lane);
    return BYTE_W'(v >> ((nbytes - 1 - lane) * BYTE_W));
  endfunction

  function automatic logic in_window(input int a, input int base, input int n);
    return (a >= base) && (a < base + n);
  endfunction
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec #(
  parameter int ADDR_W     = 4,
  parameter int NBYTES     = 4,
  parameter int ACT_ADDR   = 0,
  parameter int STORE_BASE = 1,
  parameter int STAT_BASE  = 5,
  localparam int LANE_W    = $clog2(NBYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              act_hit,
  output logic              st_hit,
  output logic              ss_hit,
  output logic [LANE_W-1:0] lane
);
  import csr_bank_pkg::*;
  int a;
  always_comb begin
    a       = int'(addr);
    act_hit = (a == ACT_ADDR);
    st_hit  = in_window(a, STORE_BASE, NBYTES);
    ss_hit  = in_window(a, STAT_BASE, NBYTES);
    if (st_hit) lane = LANE_W'(a - STORE_BASE);
    else if (ss_hit) lane = LANE_W'(a - STAT_BASE);
    else lane = '0;
  end
endmodule

// File: rtl/csr_staged_reg.sv
module csr_staged_reg #(
  parameter int REG_W           = 32,
  parameter logic [REG_W-1:0] RESET_VAL = 32'h1234_5678,
  localparam int NBYTES         = REG_W / csr_bank_pkg::BYTE_W,
  localparam int LANE_W         = $clog2(NBYTES),
  localparam int UP_W           = REG_W - csr_bank_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        wdata,
  input  logic              ovr_en,
  input  logic [REG_W-1:0]  ovr_data,
  output logic              commit,
  output logic [REG_W-1:0]  value
);
  logic [UP_W-1:0] upper_w;

  for (genvar g = 0; g < NBYTES - 1; g++) begin : g_shadow
    logic [7:0] sb;
    always_ff @(posedge clk) begin
      if (!rst_n) sb <= '0;
      else if (wr_en && lane == LANE_W'(g)) sb <= wdata;
    end
    assign upper_w[(NBYTES-2-g)*8 +: 8] = sb;
  end

  assign commit = wr_en && (lane == LANE_W'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) value <= RESET_VAL;
    else if (ovr_en) value <= ovr_data;
    else if (commit) value <= {upper_w, wdata};
  end
endmodule

// File: rtl/csr_status_reg.sv
module csr_status_reg #(
  parameter int REG_W = 32,
  parameter logic [REG_W-1:0] RESET_VAL = 32'h1234_5678
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic [REG_W-1:0] sample_data,
  output logic [REG_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n) value <= RESET_VAL;
    else if (sample_en) value <= sample_data;
  end
endmodule

// File: rtl/csr_byte_bank.sv
module csr_byte_bank #(
  parameter int ADDR_W     = 4,
  parameter int REG_W      = 32,
  parameter int ACT_ADDR   = 0,
  parameter int STORE_BASE = 1,
  parameter int STAT_BASE  = 5,
  parameter logic [REG_W-1:0] RESET_VAL = 32'h1234_5678,
  parameter logic [REG_W-1:0] KICK_LOAD = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              kick_pulse,
  output logic              stat_rd_pulse,
  output logic [REG_W-1:0]  ctl_value,
  input  logic              dev_ovr_en,
  input  logic [REG_W-1:0]  dev_ovr_data
);
  import csr_bank_pkg::*;
  localparam int NBYTES = REG_W / BYTE_W;
  localparam int LANE_W = $clog2(NBYTES);

  logic              act_hit, st_hit, ss_hit;
  logic [LANE_W-1:0] lane;
  logic              store_wr, store_commit, ovr_en;
  logic [REG_W-1:0]  ovr_data, stat_value;

  csr_addr_dec #(
    .ADDR_W(ADDR_W), .NBYTES(NBYTES), .ACT_ADDR(ACT_ADDR),
    .STORE_BASE(STORE_BASE), .STAT_BASE(STAT_BASE)
  ) u_dec (
    .addr(bus_addr), .act_hit(act_hit), .st_hit(st_hit),
    .ss_hit(ss_hit), .lane(lane)
  );

  assign kick_pulse    = bus_we && act_hit;
  assign stat_rd_pulse = bus_re && ss_hit;
  assign store_wr      = bus_we && st_hit;
  // The kick reaches the control value through the device override path.
  assign ovr_en        = kick_pulse || dev_ovr_en;
  assign ovr_data      = kick_pulse ? KICK_LOAD : dev_ovr_data;

  csr_staged_reg #(.REG_W(REG_W), .RESET_VAL(RESET_VAL)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(store_wr), .lane(lane),
    .wdata(bus_wdata), .ovr_en(ovr_en), .ovr_data(ovr_data),
    .commit(store_commit), .value(ctl_value)
  );

  csr_status_reg #(.REG_W(REG_W), .RESET_VAL(RESET_VAL)) u_stat (
    .clk(clk), .rst_n(rst_n), .sample_en(kick_pulse),
    .sample_data(ctl_value), .value(stat_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) begin
      if (st_hit) bus_rdata <= lane_byte(64'(ctl_value), NBYTES, int'(lane));
      else if (ss_hit) bus_rdata <= lane_byte(64'(stat_value), NBYTES, int'(lane));
      else bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/csr_byte_bank_chk.sv
module csr_byte_bank_chk #(
  parameter int ADDR_W = 4,
  parameter int REG_W  = 32,
  parameter int STAT_BASE = 5,
  parameter logic [REG_W-1:0] KICK_LOAD = 32'hDEAD_BEEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [7:0]        bus_rdata,
  input logic              kick_pulse,
  input logic              stat_rd_pulse,
  input logic [REG_W-1:0]  ctl_value,
  input logic [REG_W-1:0]  stat_value,
  input logic              store_commit,
  input logic              ovr_en
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  a_r5_kick_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    kick_pulse |-> bus_we);
  a_r7_read_pulse_needs_re: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_pulse |-> bus_re);
  a_r5_kick_loads_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_pulse && past_ok) |=> (ctl_value == KICK_LOAD));
  a_r6_status_takes_prior: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_pulse && past_ok) |=> (stat_value == $past(ctl_value)));
  a_r4_status_only_on_kick: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !kick_pulse) |=> $stable(stat_value));
  a_r3_ctl_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !store_commit && !ovr_en) |=> $stable(ctl_value));
  a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !bus_re) |=> $stable(bus_rdata));
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && (int'(bus_addr) == 0 || int'(bus_addr) >= STAT_BASE + REG_W/8))
    |=> (bus_rdata == 8'h00));
endmodule

bind csr_byte_bank csr_byte_bank_chk #(
  .ADDR_W(ADDR_W), .REG_W(REG_W), .STAT_BASE(STAT_BASE), .KICK_LOAD(KICK_LOAD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_re(bus_re), .bus_rdata(bus_rdata), .kick_pulse(kick_pulse),
  .stat_rd_pulse(stat_rd_pulse), .ctl_value(ctl_value),
  .stat_value(stat_value), .store_commit(store_commit), .ovr_en(ovr_en)
);

// File: tb/sim_csr_byte_bank.sv
module sim_csr_byte_bank;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        kick_pulse, stat_rd_pulse;
  logic [31:0] ctl_value;
  logic        dev_ovr_en = 1'b0;
  logic [31:0] dev_ovr_data = '0;

  int n_cmp = 0, n_bad = 0;
  logic done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  csr_byte_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kick_pulse(kick_pulse), .stat_rd_pulse(stat_rd_pulse),
    .ctl_value(ctl_value), .dev_ovr_en(dev_ovr_en), .dev_ovr_data(dev_ovr_data)
  );

  // Vector: {is_read, addr[3:0], data[7:0]}; for reads data is the expected byte.
  localparam int NV = 24;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0,4'd1,8'h5A},{1'b0,4'd2,8'h5A},{1'b0,4'd3,8'h5A},{1'b0,4'd4,8'h5A},
    {1'b1,4'd1,8'h5A},{1'b1,4'd2,8'h5A},{1'b1,4'd3,8'h5A},{1'b1,4'd4,8'h5A},
    {1'b0,4'd1,8'hA5},{1'b0,4'd2,8'hA5},{1'b0,4'd3,8'hA5},{1'b0,4'd4,8'hA5},
    {1'b1,4'd1,8'hA5},{1'b1,4'd2,8'hA5},{1'b1,4'd3,8'hA5},{1'b1,4'd4,8'hA5},
    {1'b0,4'd5,8'h5A},{1'b0,4'd6,8'h5A},{1'b0,4'd7,8'hA5},{1'b0,4'd8,8'hA5},
    {1'b1,4'd5,8'h12},{1'b1,4'd6,8'h34},{1'b1,4'd7,8'h56},{1'b1,4'd8,8'h78}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd32(input logic [3:0] base, output logic [31:0] v);
    logic [7:0] b;
    v = '0;
    for (int i = 0; i < 4; i++) begin
      rd(base + 4'(i), b);
      v = {v[23:0], b};
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctl", ctl_value, 32'h1234_5678);
    check("R1 rdata", 32'(bus_rdata), 32'h0);
    check("R1 kick", 32'(kick_pulse), 32'h0);
    rd32(4'd5, v);
    check("R1 status", v, 32'h1234_5678);

    // R2 R3 R4 table: round trips and status write immunity
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][12]) begin
        rd(VEC[i][11:8], b);
        check("R2/R3/R4 table read", 32'(b), 32'(VEC[i][7:0]));
      end else wr(VEC[i][11:8], VEC[i][7:0]);
    end
    check("R3 ctl after table", ctl_value, 32'hA5A5_A5A5);

    // R3 staged commit
    wr(4'd1, 8'h11); wr(4'd2, 8'h22); wr(4'd3, 8'h33);
    check("R3 no change before lsb", ctl_value, 32'hA5A5_A5A5);
    wr(4'd4, 8'h44);
    check("R3 atomic commit", ctl_value, 32'h1122_3344);

    // R5 kick pulse, R6 status sampling
    bus_addr = 4'd0; bus_we = 1'b1;
    #1;
    check("R5 kick same cycle", 32'(kick_pulse), 32'h1);
    @(negedge clk);
    bus_we = 1'b0;
    #1;
    check("R5 kick single cycle", 32'(kick_pulse), 32'h0);
    check("R5 ctl loaded", ctl_value, 32'hDEAD_BEEF);
    rd32(4'd5, v);
    check("R6 status after first kick", v, 32'h1122_3344);
    wr(4'd0, 8'h01);
    rd32(4'd5, v);
    check("R6 status after second kick", v, 32'hDEAD_BEEF);

    // R7 parked address, R8 hold
    bus_addr = 4'd6;
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R7 no pulse when parked", 32'(stat_rd_pulse), 32'h0);
      @(negedge clk);
      check("R8 rdata held", 32'(bus_rdata), 32'hEF);
    end
    bus_re = 1'b1;
    #1;
    check("R7 pulse with re", 32'(stat_rd_pulse), 32'h1);
    @(negedge clk);
    bus_re = 1'b0;
    check("R8 registered byte", 32'(bus_rdata), 32'hAD);

    // R8 unmapped and action reads
    rd(4'd0, b);
    check("R8 action reads zero", 32'(b), 32'h0);
    rd(4'd2, b);
    rd(4'd12, b);
    check("R8 unmapped reads zero", 32'(b), 32'h0);

    // R9 override priority and plain override
    wr(4'd1, 8'h01); wr(4'd2, 8'h02); wr(4'd3, 8'h03);
    bus_addr = 4'd4; bus_wdata = 8'h04; bus_we = 1'b1;
    dev_ovr_en = 1'b1; dev_ovr_data = 32'hCAFE_F00D;
    @(negedge clk);
    bus_we = 1'b0; dev_ovr_en = 1'b0;
    check("R9 override wins", ctl_value, 32'hCAFE_F00D);
    dev_ovr_en = 1'b1; dev_ovr_data = 32'h0BAD_C0DE;
    @(negedge clk);
    dev_ovr_en = 1'b0;
    rd32(4'd1, v);
    check("R9 override readback", v, 32'h0BAD_C0DE);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule